// File: doc/BRIEF.md
# Segment Descriptor Cache and Access Checker

This block is the address stage of a protected-mode processor. It keeps one cached descriptor per segment register, four in all. Software loads a segment register by presenting the selector together with the descriptor it names on a load port. The block captures the selector, base, limit and rights into that register's entry. Descriptor table walks happen elsewhere. The cached entries are used only inside this block; no port reads them back.

Every reference gives a segment index, a 16-bit offset and an operation: read, write or code fetch. In protected mode the block checks the offset against the cached limit and the rights against the operation, then adds the offset to the 24-bit base. In real mode it forms the selector times 16 plus the offset within 20 bits and performs no checks. The check itself is combinational. Its result is registered, so each reference produces exactly one outcome one clock later: a valid physical address, or a fault with a code.

Top module: `seg_xlate_unit`

## Requirements
- R1: While `rst_ni` is low and after it rises, `pa_valid_o`, `fault_o`, `fault_code_o` and `pa_o` are zero, and all four entries are marked not present.
- R2: A cycle with `ld_valid_i` high writes selector, base, limit and rights into the entry chosen by `ld_seg_i`. The other three entries keep their contents. The rights field is [2]=present, [1]=executable, [0]=read/write permission: writable for data, readable for code.
- R3: A protected-mode reference that passes its checks gives `pa_valid_o`=1 on the next cycle, with `pa_o` = (base + zero-extended offset) mod 2^24.
- R4: An offset strictly greater than the cached limit faults with code 1. An offset equal to the limit is allowed.
- R5: The rights checks fault with code 2 in these cases: a write (`req_op_i`=1) to a code segment or a non-writable data segment; a read (`req_op_i`=0 or 3) from a code segment without read permission; a fetch (`req_op_i`=2) from a data segment.
- R6: A protected-mode reference to an entry whose present bit is clear faults with code 3. When several checks fail, code 3 takes precedence over code 1, and code 1 over code 2.
- R7: In real mode (`real_mode_i`=1), `pa_o` = ({selector,4'h0} + offset) mod 2^20, zero-extended to 24 bits. Real mode never faults, whatever the rights, limit or present bit.
- R8: Each cycle with `req_valid_i` high gives exactly one of `pa_valid_o` or `fault_o` on the next cycle. On a fault `pa_o` is zero. A cycle without a request leaves both low on the next cycle.
- R9: A load and a reference to the same entry in the same cycle: the reference sees the entry's previous contents, and the new contents apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| real_mode_i | input | 1 | 1 selects real-mode addressing |
| ld_valid_i | input | 1 | Load strobe for a descriptor entry |
| ld_seg_i | input | 2 | Entry to load |
| ld_sel_i | input | 16 | Selector value loaded into the segment register |
| ld_base_i | input | 24 | Descriptor base |
| ld_limit_i | input | 16 | Descriptor limit, the highest valid offset |
| ld_rights_i | input | 3 | {present, executable, read/write permission} |
| req_valid_i | input | 1 | Reference strobe |
| req_seg_i | input | 2 | Segment used by the reference |
| req_op_i | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_off_i | input | 16 | Offset within the segment |
| pa_valid_o | output | 1 | Registered: physical address is valid |
| pa_o | output | 24 | Registered physical address |
| fault_o | output | 1 | Registered protection fault |
| fault_code_o | output | 2 | 0 none, 1 limit, 2 rights, 3 not present |

## Verification
The hardest case to reach from the ports is a load and a reference to the same entry in one cycle. The design must answer from the old contents, and a one-cycle slip in the cache write would go unnoticed in any sequence that separates the two. The driver can issue a load and a request on the same edge, and its model computes the expected result before it applies the load. This case is followed by a reference to the same entry under the new descriptor. Precedence between faults is reached with descriptors that fail more than one check at once: an absent entry with an offset far past the limit, and an execute-only segment read beyond its limit.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FETCH = 2'd2,
    OP_READ2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LIMIT  = 2'd1,
    FLT_RIGHTS = 2'd2,
    FLT_ABSENT = 2'd3
  } flt_e;

  typedef struct packed {
    logic present;
    logic exec;
    logic rw;
  } rights_t;
endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_xlate_pkg::*;
#(
  parameter int SEG_N  = 4,
  parameter int IDX_W  = (SEG_N > 1) ? $clog2(SEG_N) : 1,
  parameter int SEL_W  = 16,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  input  logic [BASE_W-1:0] ld_base_i,
  input  logic [LIM_W-1:0]  ld_limit_i,
  input  rights_t           ld_rights_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [SEL_W-1:0]  rd_sel_o,
  output logic [BASE_W-1:0] rd_base_o,
  output logic [LIM_W-1:0]  rd_limit_o,
  output rights_t           rd_rights_o
);
  logic [SEL_W-1:0]  sel_q   [SEG_N];
  logic [BASE_W-1:0] base_q  [SEG_N];
  logic [LIM_W-1:0]  limit_q [SEG_N];
  rights_t           rt_q    [SEG_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SEG_N; i++) begin
        sel_q[i]   <= '0;
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        rt_q[i]    <= '0;
      end
    end else begin
      for (int i = 0; i < SEG_N; i++) begin
        if (ld_en_i && ld_idx_i == IDX_W'(i)) begin
          sel_q[i]   <= ld_sel_i;
          base_q[i]  <= ld_base_i;
          limit_q[i] <= ld_limit_i;
          rt_q[i]    <= ld_rights_i;
        end
      end
    end
  end

  // read returns pre-load contents when load and lookup collide
  assign rd_sel_o    = sel_q[rd_idx_i];
  assign rd_base_o   = base_q[rd_idx_i];
  assign rd_limit_o  = limit_q[rd_idx_i];
  assign rd_rights_o = rt_q[rd_idx_i];
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int RA_W  = SEL_W + 4
) (
  input  logic             real_mode_i,
  input  logic [1:0]       op_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [OFF_W-1:0] limit_i,
  input  rights_t          rights_i,
  output logic             ok_o,
  output flt_e             code_o,
  output logic [PA_W-1:0]  pa_o
);
  logic [RA_W-1:0] real_sum;
  logic [PA_W-1:0] prot_sum;
  logic            rights_ok;

  always_comb begin
    real_sum = {sel_i, 4'h0} + RA_W'(off_i);
    prot_sum = base_i + PA_W'(off_i);

    unique case (op_e'(op_i))
      OP_WRITE: rights_ok = !rights_i.exec && rights_i.rw;
      OP_FETCH: rights_ok = rights_i.exec;
      default:  rights_ok = !rights_i.exec || rights_i.rw;
    endcase

    if (real_mode_i)             code_o = FLT_NONE;
    else if (!rights_i.present)  code_o = FLT_ABSENT;
    else if (off_i > limit_i)    code_o = FLT_LIMIT;
    else if (!rights_ok)         code_o = FLT_RIGHTS;
    else                         code_o = FLT_NONE;

    ok_o = (code_o == FLT_NONE);
    if (!ok_o)            pa_o = '0;
    else if (real_mode_i) pa_o = PA_W'(real_sum);
    else                  pa_o = prot_sum;
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_N = 4,
  parameter int SEL_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int IDX_W = (SEG_N > 1) ? $clog2(SEG_N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             real_mode_i,
  input  logic             ld_valid_i,
  input  logic [IDX_W-1:0] ld_seg_i,
  input  logic [SEL_W-1:0] ld_sel_i,
  input  logic [PA_W-1:0]  ld_base_i,
  input  logic [OFF_W-1:0] ld_limit_i,
  input  logic [2:0]       ld_rights_i,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] req_seg_i,
  input  logic [1:0]       req_op_i,
  input  logic [OFF_W-1:0] req_off_i,
  output logic             pa_valid_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             fault_o,
  output logic [1:0]       fault_code_o
);
  logic [SEL_W-1:0] c_sel;
  logic [PA_W-1:0]  c_base;
  logic [OFF_W-1:0] c_limit;
  rights_t          c_rights;
  logic             chk_ok;
  flt_e             chk_code;
  logic [PA_W-1:0]  chk_pa;

  seg_desc_cache #(
    .SEG_N(SEG_N), .IDX_W(IDX_W), .SEL_W(SEL_W), .BASE_W(PA_W), .LIM_W(OFF_W)
  ) i_cache (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_en_i     (ld_valid_i),
    .ld_idx_i    (ld_seg_i),
    .ld_sel_i    (ld_sel_i),
    .ld_base_i   (ld_base_i),
    .ld_limit_i  (ld_limit_i),
    .ld_rights_i (rights_t'(ld_rights_i)),
    .rd_idx_i    (req_seg_i),
    .rd_sel_o    (c_sel),
    .rd_base_o   (c_base),
    .rd_limit_o  (c_limit),
    .rd_rights_o (c_rights)
  );

  seg_access_check #(
    .SEL_W(SEL_W), .OFF_W(OFF_W), .PA_W(PA_W)
  ) i_check (
    .real_mode_i (real_mode_i),
    .op_i        (req_op_i),
    .off_i       (req_off_i),
    .sel_i       (c_sel),
    .base_i      (c_base),
    .limit_i     (c_limit),
    .rights_i    (c_rights),
    .ok_o        (chk_ok),
    .code_o      (chk_code),
    .pa_o        (chk_pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_valid_o   <= 1'b0;
      fault_o      <= 1'b0;
      fault_code_o <= 2'd0;
      pa_o         <= '0;
    end else if (req_valid_i) begin
      pa_valid_o   <= chk_ok;
      fault_o      <= !chk_ok;
      fault_code_o <= chk_code;
      pa_o         <= chk_pa;
    end else begin
      pa_valid_o   <= 1'b0;
      fault_o      <= 1'b0;
      fault_code_o <= 2'd0;
      pa_o         <= '0;
    end
  end
endmodule

// File: rtl/seg_xlate_unit_chk.sv
module seg_xlate_unit_chk #(
  parameter int PA_W = 24,
  parameter int RA_W = 20
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            real_mode_i,
  input logic            req_valid_i,
  input logic            pa_valid_o,
  input logic [PA_W-1:0] pa_o,
  input logic            fault_o,
  input logic [1:0]      fault_code_o
);
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (pa_valid_o != fault_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!pa_valid_o && !fault_o)); // R8
  AST_FAULT_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (pa_o == '0)); // R8
  AST_FAULT_HAS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_code_o != 2'd0)); // R4
  AST_REAL_NEVER_FAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && real_mode_i) |=> (pa_valid_o && !fault_o)); // R7
  AST_REAL_ADDR_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && real_mode_i) |=> (pa_o[PA_W-1:RA_W] == '0)); // R7
  AST_VALID_NO_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_valid_o |-> (fault_code_o == 2'd0)); // R8
endmodule

bind seg_xlate_unit seg_xlate_unit_chk #(.PA_W(PA_W), .RA_W(SEL_W + 4)) i_chk (.*);

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        real_mode = 1'b0;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic [23:0] ld_base = '0;
  logic [15:0] ld_limit = '0;
  logic [2:0]  ld_rights = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_seg = '0;
  logic [1:0]  req_op = '0;
  logic [15:0] req_off = '0;
  logic        pa_valid;
  logic [23:0] pa;
  logic        fault;
  logic [1:0]  fault_code;

  always #(CLK_PERIOD / 2) clk = ~clk;

  seg_xlate_unit i_seg_xlate_unit (
    .clk_i(clk), .rst_ni(rst_n), .real_mode_i(real_mode),
    .ld_valid_i(ld_valid), .ld_seg_i(ld_seg), .ld_sel_i(ld_sel),
    .ld_base_i(ld_base), .ld_limit_i(ld_limit), .ld_rights_i(ld_rights),
    .req_valid_i(req_valid), .req_seg_i(req_seg), .req_op_i(req_op),
    .req_off_i(req_off), .pa_valid_o(pa_valid), .pa_o(pa),
    .fault_o(fault), .fault_code_o(fault_code)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model of the four entries
  logic [15:0] m_sel [4];
  logic [23:0] m_base [4];
  logic [15:0] m_lim [4];
  logic [2:0]  m_rt [4];

  logic [27:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [27:0] model(int s, logic [1:0] op, logic [15:0] off, bit rm);
    logic [19:0] ra;
    logic [1:0]  c;
    if (rm) begin
      ra = {m_sel[s], 4'h0} + 20'(off);
      return {1'b1, 1'b0, 2'd0, 4'h0, ra};
    end
    if (!m_rt[s][2])                                   c = 2'd3;
    else if (off > m_lim[s])                           c = 2'd1;
    else if ((op == 2'd1 && (m_rt[s][1] || !m_rt[s][0])) ||
             (op == 2'd2 && !m_rt[s][1]) ||
             ((op == 2'd0 || op == 2'd3) && m_rt[s][1] && !m_rt[s][0])) c = 2'd2;
    else                                               c = 2'd0;
    if (c != 2'd0) return {1'b0, 1'b1, c, 24'h0};
    return {1'b1, 1'b0, 2'd0, m_base[s] + 24'(off)};
  endfunction

  task automatic step(input bit do_ld, input logic [1:0] ls, input logic [15:0] lsel,
                      input logic [23:0] lb, input logic [15:0] ll, input logic [2:0] lr,
                      input bit do_rq, input logic [1:0] rs, input logic [1:0] op,
                      input logic [15:0] off, input bit rm, input string tag);
    @(negedge clk);
    ld_valid = do_ld; ld_seg = ls; ld_sel = lsel; ld_base = lb; ld_limit = ll; ld_rights = lr;
    req_valid = do_rq; req_seg = rs; req_op = op; req_off = off; real_mode = rm;
    if (do_rq) begin
      exp_q.push_back(model(int'(rs), op, off, rm));
      tag_q.push_back(tag);
    end
    if (do_ld) begin
      m_sel[ls] = lsel; m_base[ls] = lb; m_lim[ls] = ll; m_rt[ls] = lr;
    end
  endtask

  task automatic load(input logic [1:0] s, input logic [15:0] sel, input logic [23:0] b,
                      input logic [15:0] l, input logic [2:0] r);
    step(1, s, sel, b, l, r, 0, 0, 0, 0, 0, "");
  endtask

  task automatic ref_(input logic [1:0] s, input logic [1:0] op, input logic [15:0] off,
                      input bit rm, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, s, op, off, rm, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  // monitor: one registered result per accepted request
  logic pend;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= 1'b0;
    else        pend <= req_valid;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pend) begin
        logic [27:0] e;
        string t;
        n_vec++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R8: result with no pending item, actual v=%0b f=%0b", pa_valid, fault);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({pa_valid, fault, fault_code, pa} !== e) begin
            n_bad++;
            $display("FAIL %s: actual v=%0b f=%0b code=%0d pa=%06h expected v=%0b f=%0b code=%0d pa=%06h",
                     t, pa_valid, fault, fault_code, pa, e[27], e[26], e[25:24], e[23:0]);
          end
        end
      end else if (pa_valid || fault) begin
        n_bad++;
        $display("FAIL R8: output without request, actual v=%0b f=%0b expected 0 0", pa_valid, fault);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_sel[i] = '0; m_base[i] = '0; m_lim[i] = '0; m_rt[i] = '0;
    end
    repeat (3) @(negedge clk);
    n_vec++;
    if ({pa_valid, fault, fault_code, pa} !== '0) begin
      n_bad++;
      $display("FAIL R1: outputs in reset actual %0b%0b %0d %06h expected all zero",
               pa_valid, fault, fault_code, pa);
    end
    rst_n = 1'b1;
    idle(2);

    // R1 R6: entries start absent
    ref_(0, 2'd0, 16'h0000, 0, "R1 absent after reset");
    ref_(3, 2'd2, 16'hFFFF, 0, "R6 absent beats limit");

    // data read/write, base 0x123400 limit 0x0FFF
    load(0, 16'h0008, 24'h123400, 16'h0FFF, 3'b101);
    ref_(0, 2'd0, 16'h0010, 0, "R3 read translate");
    ref_(0, 2'd1, 16'h0FFF, 0, "R4 offset equal limit");
    ref_(0, 2'd1, 16'h1000, 0, "R4 offset above limit");
    ref_(0, 2'd2, 16'h0004, 0, "R5 fetch from data");

    // read-only data, base near top, wraps
    load(1, 16'h0010, 24'hFFF000, 16'hFFFF, 3'b100);
    ref_(1, 2'd1, 16'h0020, 0, "R5 write to read-only");
    ref_(1, 2'd3, 16'h1800, 0, "R3 wrap mod 2^24");

    // execute-only code
    load(2, 16'hFFFF, 24'h050000, 16'h00FF, 3'b110);
    ref_(2, 2'd2, 16'h00FF, 0, "R5 fetch exec-only");
    ref_(2, 2'd0, 16'h0040, 0, "R5 read exec-only");
    ref_(2, 2'd1, 16'h0040, 0, "R5 write to code");
    ref_(2, 2'd0, 16'h0200, 0, "R6 limit beats rights");

    // readable code
    load(3, 16'h0123, 24'h0A0000, 16'h7FFF, 3'b111);
    ref_(3, 2'd0, 16'h7000, 0, "R5 read readable code");
    ref_(3, 2'd2, 16'h0001, 0, "R2 entry 3 fetch");
    ref_(0, 2'd0, 16'h0FFE, 0, "R2 entry 0 kept");

    // R9: same-cycle load and reference to entry 1
    step(1, 1, 16'h0020, 24'h200000, 16'h0010, 3'b101, 1, 1, 2'd0, 16'h0800, 0, "R9 old contents");
    ref_(1, 2'd0, 16'h0800, 0, "R9 new limit applies");
    ref_(1, 2'd1, 16'h0010, 0, "R9 new rights applies");

    // R7 real mode
    ref_(2, 2'd1, 16'hFFFF, 1, "R7 real wrap 20 bits");
    ref_(3, 2'd2, 16'h0005, 1, "R7 real add");
    load(0, 16'h0000, 24'h0, 16'h0, 3'b000);
    ref_(0, 2'd1, 16'hABCD, 1, "R7 real ignores absent");
    ref_(0, 2'd1, 16'hABCD, 0, "R6 reload to absent");

    // back-to-back mixed pattern
    for (int k = 0; k < 24; k++)
      ref_(2'(k), 2'(k >> 2), 16'(k * 16'h0391), k[3], "R3 mixed pattern");

    idle(3);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R8: %0d results missing, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule